// File: doc/BRIEF.md
# Switch-Detect SPI Polling Controller

This block is a host-side engine that owns a 22-input switch-detection device on an SPI link. Once `start` is pulsed it runs a fixed bring-up: a reset command, a settling wait counted in prescaled ticks, two commands that take both input banks out of tri-state, and two that select the low wetting current for both banks. It then enters a ready state and reads the device status on a fixed tick period, or at once when `pollNow` is pulsed.

Every transfer is a 24-bit full-duplex frame. The reply to every frame replaces a stored status word. The low 22 bits of that word drive the switch inputs, and the two top bits drive the thermal and interrupt flags. A one-cycle `validPulse` marks each new word. If any reply during bring-up reads as all ones, the link is taken as dead: the controller parks in a failed state and stays silent until reset.

Top module: `swdet_poller`

## Requirements
- R1: After reset `csN` is high, `sck` is low, and `ready`, `failed` and `validPulse` are low. No frame starts until `start` is pulsed.
- R2: The first frame after `start` carries 0x7F0000. Chip select of the next frame falls no earlier than SETTLE_TICKS*TICK_DIV clock cycles after the reset frame's chip select rose.
- R3: After the settle wait, the frames 0x090000, 0x0A0000, 0x040000 and 0x050000 follow in that order.
- R4: `ready` rises after the last bring-up frame completes and then stays high until reset.
- R5: In the ready state a status frame 0x000000 starts every POLL_TICKS*TICK_DIV cycles, measured from one chip-select fall to the next, within 4 cycles. A `pollNow` pulse while idle starts one within 4 cycles. A `pollNow` pulse during a frame queues one more status frame.
- R6: Each frame has 24 SCK periods with `csN` low throughout. The link uses SPI mode 1: SCK idles low, MOSI changes on the rising edge, MISO is sampled on the falling edge, and bits go MSB first. Between frames `csN` stays high for at least CS_GAP cycles.
- R7: The reply of each frame is stored with `swIn` = bits 21:0, `intFlag` = bit 22 and `thermal` = bit 23. The outputs hold until the next frame ends.
- R8: `validPulse` is high for exactly one cycle per completed frame, in the same cycle the status outputs take the new word.
- R9: A bring-up reply of 0xFFFFFF sets `failed`. After that, `ready` never rises, no further frame starts, and `start` is ignored until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins bring-up from the disabled state |
| pollNow | input | 1 | Requests an immediate status read |
| miso | input | 1 | Serial data from the device |
| sck | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data to the device |
| csN | output | 1 | Active-low chip select |
| ready | output | 1 | Bring-up finished, polling active |
| failed | output | 1 | Bring-up saw a dead link |
| swIn | output | 22 | Latched switch input states |
| intFlag | output | 1 | Latched interrupt flag from the reply |
| thermal | output | 1 | Latched thermal diagnostic, shared by all inputs |
| validPulse | output | 1 | One-cycle strobe on each new status word |

## Verification
The bench builds the block with HALF_DIV=2, TICK_DIV=10, SETTLE_TICKS=30, POLL_TICKS=200 and CS_GAP=4. At these values the settle wait is 300 cycles and the poll period is 2000 cycles, so the full bring-up, two timed polls, an early poll, a queued poll and a separate failed-link run all complete within a few thousand cycles. The small SCK divide keeps each half period at two cycles. That makes any slip in MISO sampling edge, bit order or frame length show up as a mismatched word.

// File: rtl/swdet_pkg.sv
package swdet_pkg;
  localparam int FRAME_W    = 24;
  localparam int NUM_INPUTS = 22;
  localparam int NUM_INIT   = 5;

  typedef enum logic [1:0] {ST_OFF = 2'd0, ST_INIT = 2'd1, ST_READY = 2'd2, ST_FAIL = 2'd3} ctlState_t;
  typedef enum logic [1:0] {PH_SEND = 2'd0, PH_WAIT = 2'd1, PH_SETTLE = 2'd2} initPhase_t;
  typedef enum logic [1:0] {DP_IDLE = 2'd0, DP_XFER = 2'd1, DP_TAIL = 2'd2, DP_GAP = 2'd3} dpPhase_t;

  // control -> datapath strobes
  typedef struct packed {
    logic               load;
    logic [FRAME_W-1:0] word;
  } dpCmd_t;

  // bring-up command list: reset, two tri-state clears, two wetting selects
  function automatic logic [FRAME_W-1:0] initFrame(input logic [2:0] idx);
    logic [7:0] op;
    case (idx)
      3'd0:    op = 8'h7F;
      3'd1:    op = 8'h09;
      3'd2:    op = 8'h0A;
      3'd3:    op = 8'h04;
      default: op = 8'h05;
    endcase
    return {op, 16'h0000};
  endfunction
endpackage

// File: rtl/swdet_dp.sv
module swdet_dp
  import swdet_pkg::*;
#(
  parameter int HALF_DIV = 4,
  parameter int CS_GAP   = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpCmd_t             cmd,
  input  logic               miso,
  output logic               sck,
  output logic               mosi,
  output logic               csN,
  output logic               busy,
  output logic               frameDone,
  output logic [FRAME_W-1:0] statusWord
);
  localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam int BIT_W = $clog2(FRAME_W);
  localparam int GAP_W = (CS_GAP > 1) ? $clog2(CS_GAP) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF_DIV - 1);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(FRAME_W - 1);
  localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(CS_GAP - 1);

  dpPhase_t           phase;
  logic [DIV_W-1:0]   divCnt;
  logic [BIT_W-1:0]   bitCnt;
  logic [GAP_W-1:0]   gapCnt;
  logic [FRAME_W-1:0] txReg;
  logic [FRAME_W-1:0] rxReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase      <= DP_IDLE;
      divCnt     <= '0;
      bitCnt     <= '0;
      gapCnt     <= '0;
      txReg      <= '0;
      rxReg      <= '0;
      statusWord <= '0;
      sck        <= 1'b0;
      mosi       <= 1'b0;
      csN        <= 1'b1;
      frameDone  <= 1'b0;
    end else begin
      frameDone <= 1'b0;
      case (phase)
        DP_IDLE: if (cmd.load) begin
          txReg  <= cmd.word;
          csN    <= 1'b0;
          divCnt <= '0;
          bitCnt <= '0;
          phase  <= DP_XFER;
        end
        DP_XFER: if (divCnt == DIV_LAST) begin
          divCnt <= '0;
          if (!sck) begin
            sck   <= 1'b1;                       // launch edge
            mosi  <= txReg[FRAME_W-1];
            txReg <= {txReg[FRAME_W-2:0], 1'b0};
          end else begin
            sck   <= 1'b0;                       // capture edge
            rxReg <= {rxReg[FRAME_W-2:0], miso};
            if (bitCnt == BIT_LAST) phase <= DP_TAIL;
            else bitCnt <= bitCnt + 1'b1;
          end
        end else begin
          divCnt <= divCnt + 1'b1;
        end
        DP_TAIL: if (divCnt == DIV_LAST) begin
          divCnt     <= '0;
          csN        <= 1'b1;
          statusWord <= rxReg;
          frameDone  <= 1'b1;
          gapCnt     <= '0;
          phase      <= DP_GAP;
        end else begin
          divCnt <= divCnt + 1'b1;
        end
        default: if (gapCnt == GAP_LAST) phase <= DP_IDLE;
                 else gapCnt <= gapCnt + 1'b1;
      endcase
    end
  end

  assign busy = (phase != DP_IDLE);
endmodule

// File: rtl/swdet_ctrl.sv
module swdet_ctrl
  import swdet_pkg::*;
#(
  parameter int TICK_DIV     = 50000,
  parameter int SETTLE_TICKS = 3,
  parameter int POLL_TICKS   = 100
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic               pollNow,
  input  logic               busy,
  input  logic               frameDone,
  input  logic [FRAME_W-1:0] rxWord,
  output dpCmd_t             cmd,
  output ctlState_t          state
);
  localparam int TCK_MAXV = (SETTLE_TICKS > POLL_TICKS) ? SETTLE_TICKS : POLL_TICKS;
  localparam int PRE_W    = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int TCK_W    = $clog2(TCK_MAXV + 1);
  localparam logic [PRE_W-1:0] PRE_LAST   = PRE_W'(TICK_DIV - 1);
  localparam logic [TCK_W-1:0] SETTLE_V   = TCK_W'(SETTLE_TICKS);
  localparam logic [TCK_W-1:0] POLL_V     = TCK_W'(POLL_TICKS);
  localparam logic [TCK_W-1:0] TCK_ALL    = {TCK_W{1'b1}};
  localparam logic [2:0]       LAST_STEP  = 3'(NUM_INIT - 1);

  initPhase_t       phase;
  logic [2:0]       stepIdx;
  logic [PRE_W-1:0] preCnt;
  logic [TCK_W-1:0] tickCnt;
  logic             pending;
  logic             pollDue;

  assign pollDue = pending || pollNow || (tickCnt == POLL_V);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_OFF;
      phase   <= PH_SEND;
      stepIdx <= '0;
      preCnt  <= '0;
      tickCnt <= '0;
      pending <= 1'b0;
      cmd     <= '0;
    end else begin
      cmd.load <= 1'b0;
      // free-running tick prescaler, saturating tick count
      if (preCnt == PRE_LAST) begin
        preCnt <= '0;
        if (tickCnt != TCK_ALL) tickCnt <= tickCnt + 1'b1;
      end else begin
        preCnt <= preCnt + 1'b1;
      end
      case (state)
        ST_OFF: if (start) begin
          state   <= ST_INIT;
          phase   <= PH_SEND;
          stepIdx <= '0;
        end
        ST_INIT: case (phase)
          PH_SEND: if (!busy && !cmd.load) begin
            cmd.load <= 1'b1;
            cmd.word <= initFrame(stepIdx);
            phase    <= PH_WAIT;
          end
          PH_WAIT: if (frameDone) begin
            if (&rxWord) begin
              state <= ST_FAIL;
            end else if (stepIdx == 3'd0) begin
              phase   <= PH_SETTLE;
              preCnt  <= '0;
              tickCnt <= '0;
            end else if (stepIdx == LAST_STEP) begin
              state   <= ST_READY;
              preCnt  <= '0;
              tickCnt <= '0;
              pending <= 1'b0;
            end else begin
              stepIdx <= stepIdx + 1'b1;
              phase   <= PH_SEND;
            end
          end
          default: if (tickCnt == SETTLE_V) begin
            stepIdx <= 3'd1;
            phase   <= PH_SEND;
          end
        endcase
        ST_READY: begin
          if (pollNow) pending <= 1'b1;
          if (!busy && !cmd.load && pollDue) begin
            cmd.load <= 1'b1;
            cmd.word <= '0;
            pending  <= 1'b0;
            preCnt   <= '0;
            tickCnt  <= '0;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/swdet_poller.sv
module swdet_poller
  import swdet_pkg::*;
#(
  parameter int HALF_DIV     = 4,
  parameter int TICK_DIV     = 50000,
  parameter int SETTLE_TICKS = 3,
  parameter int POLL_TICKS   = 100,
  parameter int CS_GAP       = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  start,
  input  logic                  pollNow,
  input  logic                  miso,
  output logic                  sck,
  output logic                  mosi,
  output logic                  csN,
  output logic                  ready,
  output logic                  failed,
  output logic [NUM_INPUTS-1:0] swIn,
  output logic                  intFlag,
  output logic                  thermal,
  output logic                  validPulse
);
  dpCmd_t             dpCmd;
  ctlState_t          ctrlState;
  logic               dpBusy;
  logic [FRAME_W-1:0] statusWord;

  swdet_ctrl #(
    .TICK_DIV(TICK_DIV), .SETTLE_TICKS(SETTLE_TICKS), .POLL_TICKS(POLL_TICKS)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .pollNow(pollNow),
    .busy(dpBusy), .frameDone(validPulse), .rxWord(statusWord),
    .cmd(dpCmd), .state(ctrlState)
  );

  swdet_dp #(.HALF_DIV(HALF_DIV), .CS_GAP(CS_GAP)) uDp (
    .clk(clk), .rstN(rstN), .cmd(dpCmd), .miso(miso),
    .sck(sck), .mosi(mosi), .csN(csN), .busy(dpBusy),
    .frameDone(validPulse), .statusWord(statusWord)
  );

  assign ready   = (ctrlState == ST_READY);
  assign failed  = (ctrlState == ST_FAIL);
  assign swIn    = statusWord[NUM_INPUTS-1:0];
  assign intFlag = statusWord[22];
  assign thermal = statusWord[23];
endmodule

// File: rtl/swdet_checks.sv
module swdet_checks
  import swdet_pkg::*;
#(
  parameter int CS_GAP = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic               csN,
  input logic               sck,
  input logic               ready,
  input logic               failed,
  input logic               validPulse,
  input logic [FRAME_W-1:0] statusBus,
  input logic [1:0]         ctrlState
);
  logic [15:0] highCnt;

  always_ff @(posedge clk) begin
    if (!rstN) highCnt <= 16'hFFFF;
    else if (csN) highCnt <= (highCnt == 16'hFFFF) ? highCnt : highCnt + 16'd1;
    else highCnt <= '0;
  end

  assert_idle_no_frame_R1: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlState == ST_OFF) |-> csN);
  assert_sck_idle_R6: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !sck);
  assert_cs_gap_R6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(csN) |-> (highCnt >= 16'(CS_GAP)));
  assert_ready_sticky_R4: assert property (@(posedge clk) disable iff (!rstN)
    ready |=> ready);
  assert_status_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !validPulse |-> $stable(statusBus));
  assert_valid_single_R8: assert property (@(posedge clk) disable iff (!rstN)
    validPulse |=> !validPulse);
  assert_fail_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    failed |=> failed);
  assert_fail_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    failed |-> (csN && !ready));
endmodule

bind swdet_poller swdet_checks #(.CS_GAP(CS_GAP)) uChecks (
  .clk(clk), .rstN(rstN), .csN(csN), .sck(sck), .ready(ready),
  .failed(failed), .validPulse(validPulse),
  .statusBus({thermal, intFlag, swIn}), .ctrlState(ctrlState)
);

// File: tb/tb_swdet_poller.sv
`timescale 1ns/1ps
module tb_swdet_poller;
  localparam int HALF_DIV = 2, TICK_DIV = 10, SETTLE_TICKS = 30, POLL_TICKS = 200, CS_GAP = 4;
  localparam int SETTLE_CYC = SETTLE_TICKS * TICK_DIV;
  localparam int POLL_CYC   = POLL_TICKS * TICK_DIV;

  logic clk = 0, rstN = 0, start = 0, pollNow = 0, miso = 0;
  logic sck, mosi, csN, ready, failed, intFlag, thermal, validPulse;
  logic [21:0] swIn;

  swdet_poller #(.HALF_DIV(HALF_DIV), .TICK_DIV(TICK_DIV), .SETTLE_TICKS(SETTLE_TICKS),
                 .POLL_TICKS(POLL_TICKS), .CS_GAP(CS_GAP)) dut (
    .clk(clk), .rstN(rstN), .start(start), .pollNow(pollNow), .miso(miso),
    .sck(sck), .mosi(mosi), .csN(csN), .ready(ready), .failed(failed),
    .swIn(swIn), .intFlag(intFlag), .thermal(thermal), .validPulse(validPulse));

  always #10 clk = ~clk;

  int checkCount = 0, failCount = 0;
  int cyc = 0, frameCount = 0, validCount = 0, lastRise = -1, minGap = 1 << 30, sckRise = 0;
  bit frameOpen = 0;
  logic [23:0] slvTx, slvRx;
  logic [23:0] expCmdQ[$], replyQ[$], expStatQ[$];
  string       expTagQ[$];
  int          fallCyc[$], fallGap[$];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checkCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic expectFrame(input logic [23:0] cmdW, input logic [23:0] reply, input string tag);
    expCmdQ.push_back(cmdW); replyQ.push_back(reply); expTagQ.push_back(tag);
  endtask

  task automatic waitFrames(input int n, input int limit);
    for (int i = 0; i < limit && frameCount < n; i++) @(negedge clk);
    check(frameCount >= n, "R5", "frame count reached", frameCount, n);
  endtask

  always @(posedge clk) cyc++;

  // SPI mode-1 device model and command scoreboard
  always @(negedge csN) if (rstN) begin
    frameOpen = 1;
    sckRise = 0;
    slvTx = (replyQ.size() > 0) ? replyQ.pop_front() : 24'h000000;
    expStatQ.push_back(slvTx);
    fallCyc.push_back(cyc);
    fallGap.push_back((lastRise < 0) ? -1 : cyc - lastRise);
    if (lastRise >= 0 && cyc - lastRise < minGap) minGap = cyc - lastRise;
  end
  always @(posedge sck) if (!csN) begin
    miso = slvTx[23];
    slvTx = {slvTx[22:0], 1'b0};
    sckRise++;
  end
  always @(negedge sck) if (!csN) slvRx = {slvRx[22:0], mosi};
  always @(posedge csN) if (frameOpen) begin
    frameOpen = 0;
    lastRise = cyc;
    check(sckRise == 24, "R6", "sck periods per frame", sckRise, 24);
    if (expCmdQ.size() == 0) check(0, "R5", "unexpected frame", slvRx, 24'hFFFFFF);
    else begin
      string tag;
      logic [23:0] e;
      e = expCmdQ.pop_front(); tag = expTagQ.pop_front();
      check(slvRx == e, tag, "command word", slvRx, e);
    end
    frameCount++;
  end

  // status monitor
  always @(negedge clk) if (rstN && validPulse) begin
    validCount++;
    if (expStatQ.size() == 0) check(0, "R8", "strobe without frame", 0, 1);
    else begin
      logic [23:0] e;
      e = expStatQ.pop_front();
      check({thermal, intFlag, swIn} == e, "R7", "status outputs", {thermal, intFlag, swIn}, e);
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    checkCount++; failCount++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  end

  initial begin
    int t0;
    repeat (5) @(posedge clk);
    @(negedge clk) rstN = 1;
    @(negedge clk);
    check(csN === 1'b1 && sck === 1'b0, "R1", "bus idle after reset", {csN, sck}, 2'b10);
    check({ready, failed, validPulse} === 3'b000, "R1", "flags after reset", {ready, failed, validPulse}, 0);
    repeat (100) @(negedge clk);
    check(frameCount == 0, "R1", "no frame before start", frameCount, 0);

    expectFrame(24'h7F0000, 24'h800000, "R2");
    expectFrame(24'h090000, 24'h400000, "R3");
    expectFrame(24'h0A0000, 24'h2AAAAA, "R3");
    expectFrame(24'h040000, 24'h155555, "R3");
    expectFrame(24'h050000, 24'h000001, "R3");
    start = 1; @(negedge clk) start = 0;
    waitFrames(4, 4000);
    check(ready === 1'b0, "R4", "not ready before last frame", ready, 0);
    waitFrames(5, 2000);
    repeat (3) @(negedge clk);
    check(ready === 1'b1 && failed === 1'b0, "R4", "ready after bring-up", {ready, failed}, 2'b10);
    check(fallGap[1] >= SETTLE_CYC && fallGap[1] <= SETTLE_CYC + 20, "R2", "settle wait cycles",
          fallGap[1], SETTLE_CYC);

    expectFrame(24'h000000, 24'hC00003, "R5");
    expectFrame(24'h000000, 24'h3F0F0F, "R5");
    waitFrames(7, 6000);
    t0 = fallCyc[6] - fallCyc[5];
    check(t0 >= POLL_CYC && t0 <= POLL_CYC + 4, "R5", "poll period", t0, POLL_CYC);

    repeat (300) @(negedge clk);
    expectFrame(24'h000000, 24'h0ABCDE, "R5");
    expectFrame(24'h000000, 24'h2C3A5F, "R5");
    t0 = cyc;
    pollNow = 1; @(negedge clk) pollNow = 0;
    for (int i = 0; i < 20 && csN; i++) @(negedge clk);
    check(fallCyc.size() == 8 && fallCyc[7] - t0 <= 4, "R5", "early poll latency", fallCyc[7] - t0, 4);
    repeat (10) @(negedge clk);
    pollNow = 1; @(negedge clk) pollNow = 0;
    waitFrames(9, 1000);
    check(fallCyc[8] - fallCyc[7] < 300, "R5", "queued poll follows", fallCyc[8] - fallCyc[7], 300);
    repeat (5) @(negedge clk);
    check(validCount == frameCount, "R8", "one strobe per frame", validCount, frameCount);
    check(minGap >= CS_GAP, "R6", "chip select high time", minGap, CS_GAP);
    check(expCmdQ.size() == 0, "R3", "all expected frames seen", expCmdQ.size(), 0);

    // dead-link run
    rstN = 0;
    repeat (3) @(negedge clk);
    expCmdQ.delete(); replyQ.delete(); expStatQ.delete(); expTagQ.delete();
    fallCyc.delete(); fallGap.delete();
    frameCount = 0; validCount = 0; lastRise = -1;
    rstN = 1;
    @(negedge clk);
    expectFrame(24'h7F0000, 24'h000000, "R2");
    expectFrame(24'h090000, 24'hFFFFFF, "R3");
    start = 1; @(negedge clk) start = 0;
    waitFrames(2, 3000);
    repeat (5) @(negedge clk);
    check(failed === 1'b1 && ready === 1'b0, "R9", "failed on dead link", {failed, ready}, 2'b10);
    repeat (2500) @(negedge clk);
    start = 1; @(negedge clk) start = 0;
    repeat (500) @(negedge clk);
    check(frameCount == 2, "R9", "silent after failure", frameCount, 2);
    check(failed === 1'b1 && ready === 1'b0, "R9", "start ignored when failed", {failed, ready}, 2'b10);

    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  end
endmodule